// File: doc/BRIEF.md
# Triple Prescaled Interval Timer

This block provides three interval timers for a small audio coprocessor. A single-cycle enable pulse, nominally at 1.024 MHz, paces all three. Each timer divides that pace by a fixed prescaler: timers 0 and 1 use a slow divider of 128, for 8 kHz, and timer 2 uses a fast divider of 16, for 64 kHz. Each prescaled tick advances an internal stage count. When the stage count reaches the timer's programmable 8-bit period, the stage count starts again from zero and the timer's 4-bit output counter steps up by one.

Software reaches the block through a byte-wide register port with a 4-bit offset:

| Offset | Access | Function |
|---|---|---|
| 0x1 | write | Enable word, one bit per timer |
| 0xA, 0xB, 0xC | write | Period registers for timers 0, 1 and 2 |
| 0xD, 0xE, 0xF | read | Output counters for timers 0, 1 and 2 |

Reading an output counter returns its value and empties it in the same access. Software therefore polls how many periods have elapsed since the last poll.

Top module: `tri_interval_timer`

## Requirements
- R1: The stage count of timers 0 and 1 advances once per 128 cycles in which `tick_en` is high. The stage count of timer 2 advances once per 16 such cycles. Cycles with `tick_en` low do not count.
- R2: The period of timers 0 to 2 is written at offsets 0xA to 0xC. A period value of 0 acts as 256 stage ticks.
- R3: When the stage count reaches the period, the stage count returns to zero and the 4-bit output counter increments, wrapping from 15 to 0.
- R4: A read strobe at offset 0xD, 0xE or 0xF returns that counter's value in bits 3:0 of `rdata`, with the upper bits 0, and clears the counter at the same clock edge. `rdata` is 0 when no counter is being read.
- R5: A write strobe at a counter offset clears that counter, whatever the data value.
- R6: Bits 0 to 2 of a write at offset 0x1 set the enables of timers 0 to 2. A bit that goes from 0 to 1 clears that timer's output counter, its stage count and its prescaler phase. Writing 1 to a timer that is already enabled clears nothing.
- R7: A disabled timer holds its stage count and its output counter.
- R8: A period write takes effect as the new compare target without clearing the stage count or the output counter. Rewriting the same period value leaves the counting phase unchanged.
- R9: If a counter clear and a counter increment fall in the same cycle, the counter ends at 1.
- R10: Reset sets every counter, period and enable to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | CPU-rate pacing pulse |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, counter value during a counter read |

## Verification
The assertions check four properties on every cycle:
- An output counter only holds or steps by one, except on a clear.
- A disabled timer stays frozen.
- A clear by read or write leaves at most 1.
- A rising enable zeroes all three stages of state.

Only the bench scenarios can show the elapsed-time behaviour:
- The exact prescaler divisions.
- The period-of-zero case.
- Wrapping after sixteen periods.
- That retargeting a period, or rewriting the same period, preserves the running stage count.
- That a read colliding with an increment returns 0 and leaves 1.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16,
  parameter int NT       = 3,
  parameter int PERW     = 8,
  parameter int CNTW     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata
);
  localparam int PW     = $clog2(SLOW_DIV);
  localparam int A_CTRL = 1;
  localparam int A_PER0 = 10;
  localparam int A_CNT0 = 13;

  logic            en    [NT];
  logic [PERW-1:0] per   [NT];
  logic [PERW:0]   stage [NT];
  logic [PW-1:0]   pre   [NT];
  logic [CNTW-1:0] cnt   [NT];

  wire ctrl_wr = wr && (addr == 4'(A_CTRL));

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam int DIV = (i < 2) ? SLOW_DIV : FAST_DIV;
    logic            rise, stick, bump, clr;
    logic [PERW:0]   tgt;

    assign rise  = ctrl_wr && wdata[i] && !en[i];
    assign stick = en[i] && tick_en && (pre[i] == PW'(DIV - 1));
    assign tgt   = (per[i] == '0) ? (PERW+1)'(1 << PERW) : {1'b0, per[i]};
    assign bump  = stick && ((stage[i] + (PERW+1)'(1)) >= tgt);
    assign clr   = (rd || wr) && (addr == 4'(A_CNT0 + i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]    <= 1'b0;
        per[i]   <= '0;
        stage[i] <= '0;
        pre[i]   <= '0;
        cnt[i]   <= '0;
      end else begin
        if (ctrl_wr) en[i] <= wdata[i];
        if (wr && addr == 4'(A_PER0 + i)) per[i] <= wdata[PERW-1:0];
        if (rise) begin
          pre[i]   <= '0;
          stage[i] <= '0;
          cnt[i]   <= '0;
        end else begin
          if (en[i] && tick_en)
            pre[i] <= (pre[i] == PW'(DIV - 1)) ? '0 : pre[i] + PW'(1);
          if (stick)
            stage[i] <= bump ? '0 : stage[i] + (PERW+1)'(1);
          if (clr)       cnt[i] <= CNTW'(bump);
          else if (bump) cnt[i] <= cnt[i] + CNTW'(1);
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NT; k++)
      if (rd && addr == 4'(A_CNT0 + k)) rdata = 8'(cnt[k]);
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int SLOW_DIV = 128,
  parameter int NT       = 3,
  parameter int PERW     = 8,
  parameter int CNTW     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      addr,
  input logic [7:0]      wdata,
  input logic            wr,
  input logic            rd,
  input logic [7:0]      rdata,
  input logic            en    [NT],
  input logic [PERW:0]   stage [NT],
  input logic [$clog2(SLOW_DIV)-1:0] pre [NT],
  input logic [CNTW-1:0] cnt   [NT]
);
  wire ctl = wr && addr == 4'd1;

  for (genvar i = 0; i < NT; i++) begin : g_chk
    localparam logic [3:0] CA = 4'(13 + i);
    wire hit = (rd || wr) && addr == CA;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !(ctl && wdata[i] && !en[i])) |=>
        (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + CNTW'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !ctl && !hit) |=> ($stable(cnt[i]) && $stable(stage[i])));

    p_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == CA) |=> (cnt[i] <= CNTW'(1)));

    p_rdval_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == CA) |-> (rdata == 8'(cnt[i])));

    p_wrclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == CA) |=> (cnt[i] <= CNTW'(1)));

    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl && wdata[i] && !en[i]) |=>
        (en[i] && cnt[i] == '0 && stage[i] == '0 && pre[i] == '0));
  end
endmodule

bind tri_interval_timer tri_interval_timer_chk #(
  .SLOW_DIV(SLOW_DIV), .NT(NT), .PERW(PERW), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .en(en), .stage(stage), .pre(pre), .cnt(cnt)
);

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;
  logic clk = 0, rst_n = 0, tick_en = 1, wr = 0, rd = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_interval_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata));

  // {timer[2], period[8], wait[16], expected[4]}
  localparam logic [29:0] VEC [10] = '{
    {2'd0, 8'd1, 16'd128,   4'd1},
    {2'd0, 8'd1, 16'd127,   4'd0},
    {2'd0, 8'd1, 16'd384,   4'd3},
    {2'd1, 8'd2, 16'd256,   4'd1},
    {2'd1, 8'd2, 16'd255,   4'd0},
    {2'd2, 8'd1, 16'd272,   4'd1},
    {2'd2, 8'd1, 16'd83,    4'd5},
    {2'd2, 8'd0, 16'd4096,  4'd1},
    {2'd2, 8'd0, 16'd4095,  4'd0},
    {2'd0, 8'd0, 16'd32768, 4'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output int v);
    addr = a; rd = 1;
    #2 v = rdata;
    @(posedge clk); @(negedge clk);
    rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      rd_reg(4'(13 + k), v);
      chk("R10 counter after reset", v, 0);
    end
    addr = 4'hA; #1;
    chk("R4 rdata idle", rdata, 0);

    for (int n = 0; n < 10; n++) begin
      logic [1:0] t; logic [7:0] p; logic [15:0] m; logic [3:0] e;
      {t, p, m, e} = VEC[n];
      wr_reg(4'h1, 8'h00);
      wr_reg(4'(10 + t), p);
      wr_reg(4'h1, 8'(1 << t));
      idle(int'(m));
      rd_reg(4'(13 + t), v);
      chk($sformatf("vector %0d R1 R2 R3", n), v, int'(e));
    end

    // R4 clear on read, R7 disabled holds, R9 collision
    wr_reg(4'h1, 8'h00); wr_reg(4'hC, 8'd1); wr_reg(4'h1, 8'h04);
    idle(32);
    wr_reg(4'h1, 8'h00);
    idle(200);
    rd_reg(4'hF, v); chk("R7 disabled holds", v, 2);
    rd_reg(4'hF, v); chk("R4 cleared by read", v, 0);
    wr_reg(4'h1, 8'h04);
    idle(15);
    rd_reg(4'hF, v); chk("R6 re-enable cleared", v, 0);
    rd_reg(4'hF, v); chk("R9 read and increment", v, 1);

    // R6 enable rewrite does not clear
    wr_reg(4'h1, 8'h00); wr_reg(4'h1, 8'h04);
    idle(32);
    wr_reg(4'h1, 8'h04);
    idle(15);
    rd_reg(4'hF, v); chk("R6 rewrite keeps count", v, 3);

    // R5 counter write clears
    wr_reg(4'h1, 8'h00); wr_reg(4'h1, 8'h04);
    idle(48);
    wr_reg(4'hF, 8'hFF);
    rd_reg(4'hF, v); chk("R5 write clears", v, 0);

    // R8 retarget without clearing
    wr_reg(4'h1, 8'h00); wr_reg(4'hC, 8'd4); wr_reg(4'h1, 8'h04);
    idle(64);
    wr_reg(4'hC, 8'd2);
    idle(31);
    rd_reg(4'hF, v); chk("R8 retarget", v, 2);

    // R8 same value keeps phase
    wr_reg(4'h1, 8'h00); wr_reg(4'hC, 8'd3); wr_reg(4'h1, 8'h04);
    idle(40);
    wr_reg(4'hC, 8'd3);
    idle(7);
    rd_reg(4'hF, v); chk("R8 same value", v, 1);

    // R1 tick_en gating
    wr_reg(4'h1, 8'h00); wr_reg(4'hC, 8'd1);
    tick_en = 0;
    wr_reg(4'h1, 8'h04);
    idle(100);
    rd_reg(4'hF, v); chk("R1 no tick no count", v, 0);
    tick_en = 1;
    idle(16);
    rd_reg(4'hF, v); chk("R1 ticks resume", v, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule